// File: doc/BRIEF.md
# Output Compare Pin Action Logic

This block is the per-channel output compare stage of a free-running timer. Each channel compares the shared timer count against its own compare value. On the first clock of equality it raises a sticky event flag. One clock later it updates its pin register according to a two-bit action code formed from a mode bit and a level bit. The action can leave the pin alone, toggle it, force it low or force it high.

A channel reacts only while its direction bit marks it as an output compare channel. Two designated channels can also give their pins to pulse accumulators. A pin is released for pulse counting only when its channel is an output compare channel, its action code is "off" and its compare-mask bit is clear. The counter, its prescaler, interrupt generation and bus decoding are outside the block.

Top module: `oc_pin_action`

## Requirements
- R1: After reset, `pin_out`, `evt_flag` and `pa_free` are all zero. With every control input low, `pin_owned` is zero.
- R2: A channel with `ch_is_oc`=1 detects a match on the first clock on which `count` equals its compare value. `evt_flag` rises at the next edge. While `count` stays equal, no further match is detected, so a flag cleared during the hold stays clear and the pin acts only once.
- R3: `evt_flag` stays set until `flag_clr` is 1 for that channel. If a match and a clear fall on the same clock, the flag ends up set.
- R4: Action code {mode,level}=00 leaves `pin_out` unchanged on a match.
- R5: Action code 01 inverts `pin_out` at the edge after the one that sets `evt_flag`.
- R6: Action code 10 drives `pin_out` to 0 at the edge after the one that sets `evt_flag`.
- R7: Action code 11 drives `pin_out` to 1 at the edge after the one that sets `evt_flag`.
- R8: A channel with `ch_is_oc`=0 sets no flag and does not change its pin when the count matches.
- R9: Bit 1 of `pa_free` belongs to channel PA_HI_CH and bit 0 belongs to channel PA_LO_CH. A bit is 1 exactly when that channel has `ch_is_oc`=1, action code 00 and `pa_mask`=0.
- R10: `pin_owned` for a channel is 1 exactly when `ch_is_oc`=1 and its action code is not 00.
- R11: Each channel matches against its own field of `cmp_val`, the field for channel i being bits [i*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | CNT_W | Timer count |
| cmp_val | input | NUM_CH*CNT_W | Compare values, channel i at [i*CNT_W +: CNT_W] |
| oc_mode | input | NUM_CH | Action code upper bit per channel |
| oc_level | input | NUM_CH | Action code lower bit per channel |
| ch_is_oc | input | NUM_CH | 1 = channel is output compare |
| pa_mask | input | NUM_CH | Compare-mask bits; only PA_HI_CH and PA_LO_CH are used |
| flag_clr | input | NUM_CH | Clears the event flag of a channel |
| pin_out | output | NUM_CH | Pin output register |
| pin_owned | output | NUM_CH | Timer currently drives the pin |
| evt_flag | output | NUM_CH | Sticky compare event flags |
| pa_free | output | 2 | Pin released to pulse accumulator (1 = high channel, 0 = low channel) |

## Verification
The bench builds the block with four channels, an 8-bit count, the high accumulator channel at 3 and the low one at 0. These values put both accumulator gates and all four action codes into a single sweep. The narrow count lets the bench place every match exactly. It also holds the count on one value for several clocks to exercise single detection, and gives one channel its own compare value to show that channels are independent.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;
   typedef enum logic [1:0] {
      ACT_OFF    = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } oc_act_e;
endpackage

// File: rtl/oc_match_stage.sv
module oc_match_stage
   import oc_pin_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp,
   input  logic             is_oc,
   input  oc_act_e          act,
   input  logic             clr,
   output logic             flag,
   output logic             hit_q,
   output oc_act_e          act_q
);
   logic eq, eq_q, hit;

   assign eq  = (count == cmp);
   assign hit = eq & ~eq_q & is_oc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eq_q  <= 1'b0;
         flag  <= 1'b0;
         hit_q <= 1'b0;
         act_q <= ACT_OFF;
      end else begin
         eq_q  <= eq;
         hit_q <= hit;
         if (hit) act_q <= act;
         if (hit)      flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end

   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_oc && !flag) |=> !flag);
endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive
   import oc_pin_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    hit_q,
   input  oc_act_e act_q,
   output logic    pin
);
   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else if (hit_q) begin
         unique case (act_q)
            ACT_TOGGLE: pin <= ~pin;
            ACT_LOW:    pin <= 1'b0;
            ACT_HIGH:   pin <= 1'b1;
            default:    pin <= pin;
         endcase
      end
   end

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_q || act_q == ACT_OFF) |=> $stable(pin));
   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && act_q == ACT_TOGGLE) |=> (pin != $past(pin)));
   p_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && act_q == ACT_LOW) |=> !pin);
   p_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && act_q == ACT_HIGH) |=> pin);
endmodule

// File: rtl/oc_pa_gate.sv
module oc_pa_gate (
   input  logic is_oc,
   input  logic mode,
   input  logic level,
   input  logic mask,
   output logic free
);
   assign free = is_oc & ~mode & ~level & ~mask;
endmodule

// File: rtl/oc_pin_action.sv
module oc_pin_action
   import oc_pin_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int CNT_W    = 16,
   parameter int PA_HI_CH = 7,
   parameter int PA_LO_CH = 0,
   parameter bit PA_EN    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        count,
   input  logic [NUM_CH*CNT_W-1:0] cmp_val,
   input  logic [NUM_CH-1:0]       oc_mode,
   input  logic [NUM_CH-1:0]       oc_level,
   input  logic [NUM_CH-1:0]       ch_is_oc,
   input  logic [NUM_CH-1:0]       pa_mask,
   input  logic [NUM_CH-1:0]       flag_clr,
   output logic [NUM_CH-1:0]       pin_out,
   output logic [NUM_CH-1:0]       pin_owned,
   output logic [NUM_CH-1:0]       evt_flag,
   output logic [1:0]              pa_free
);
   localparam int CMP_W = NUM_CH * CNT_W;

   if (NUM_CH < 2) begin : g_chk_ch
      $error("NUM_CH must be at least 2");
   end
   if (CNT_W < 2) begin : g_chk_w
      $error("CNT_W must be at least 2");
   end
   if (PA_HI_CH >= NUM_CH || PA_LO_CH >= NUM_CH || PA_HI_CH == PA_LO_CH) begin : g_chk_pa
      $error("accumulator channels must be distinct and in range");
   end
   if (CMP_W != $bits(cmp_val)) begin : g_chk_cmp
      $error("compare bus width mismatch");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      oc_act_e act, act_q;
      logic    hit_q;

      assign act = oc_act_e'({oc_mode[i], oc_level[i]});

      oc_match_stage #(.CNT_W(CNT_W)) u_match (
         .clk   (clk),
         .rst_n (rst_n),
         .count (count),
         .cmp   (cmp_val[i*CNT_W +: CNT_W]),
         .is_oc (ch_is_oc[i]),
         .act   (act),
         .clr   (flag_clr[i]),
         .flag  (evt_flag[i]),
         .hit_q (hit_q),
         .act_q (act_q)
      );

      oc_pin_drive u_drive (
         .clk   (clk),
         .rst_n (rst_n),
         .hit_q (hit_q),
         .act_q (act_q),
         .pin   (pin_out[i])
      );

      assign pin_owned[i] = ch_is_oc[i] & (act != ACT_OFF);
   end

   if (PA_EN) begin : g_pa
      oc_pa_gate u_pa_hi (
         .is_oc (ch_is_oc[PA_HI_CH]),
         .mode  (oc_mode[PA_HI_CH]),
         .level (oc_level[PA_HI_CH]),
         .mask  (pa_mask[PA_HI_CH]),
         .free  (pa_free[1])
      );
      oc_pa_gate u_pa_lo (
         .is_oc (ch_is_oc[PA_LO_CH]),
         .mode  (oc_mode[PA_LO_CH]),
         .level (oc_level[PA_LO_CH]),
         .mask  (pa_mask[PA_LO_CH]),
         .free  (pa_free[0])
      );
   end else begin : g_no_pa
      assign pa_free = 2'b00;
   end

   always_comb begin
      p_pa_excl_r9: assert (!(pa_free[1] && pin_owned[PA_HI_CH]) &&
                            !(pa_free[0] && pin_owned[PA_LO_CH]));
   end

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0 && evt_flag == '0));
endmodule

// File: tb/oc_pin_action_tb_top.sv
module oc_pin_action_tb_top;
   localparam int NCH = 4;
   localparam int CW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0]     count = '0;
   logic [NCH*CW-1:0] cmp_val = '0;
   logic [NCH-1:0]    oc_mode = '0, oc_level = '0, ch_is_oc = '0;
   logic [NCH-1:0]    pa_mask = '0, flag_clr = '0;
   logic [NCH-1:0]    pin_out, pin_owned, evt_flag;
   logic [1:0]        pa_free;

   always #2 clk = ~clk;

   oc_pin_action #(.NUM_CH(NCH), .CNT_W(CW), .PA_HI_CH(3), .PA_LO_CH(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .count(count), .cmp_val(cmp_val),
      .oc_mode(oc_mode), .oc_level(oc_level), .ch_is_oc(ch_is_oc),
      .pa_mask(pa_mask), .flag_clr(flag_clr), .pin_out(pin_out),
      .pin_owned(pin_owned), .evt_flag(evt_flag), .pa_free(pa_free)
   );

   typedef struct {
      string req;
      int    kind;
      int    bitn;
      logic  exp;
   } item_t;

   item_t sb_q[$];
   event  sample_ev;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   function automatic logic actual_of(int kind, int bitn);
      case (kind)
         0: return pin_out[bitn];
         1: return evt_flag[bitn];
         2: return pin_owned[bitn];
         default: return pa_free[bitn];
      endcase
   endfunction

   // monitor: pops and compares queued expectations
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic  act;
            it  = sb_q.pop_front();
            act = actual_of(it.kind, it.bitn);
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d bit=%0d actual=%b expected=%b",
                        it.req, it.kind, it.bitn, act, it.exp);
            end
         end
      end
   end

   task automatic expect_vec(string req, int kind, logic [NCH-1:0] v, int w = NCH);
      for (int b = 0; b < w; b++) begin
         item_t it;
         it.req = req; it.kind = kind; it.bitn = b; it.exp = v[b];
         sb_q.push_back(it);
      end
   endtask

   task automatic compare_now();
      -> sample_ev;
      #0.5;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_all_cmp(logic [CW-1:0] v);
      for (int c = 0; c < NCH; c++) cmp_val[c*CW +: CW] = v;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(); step();
      // R1 reset state
      expect_vec("R1 pin", 0, 4'b0000);
      expect_vec("R1 flag", 1, 4'b0000);
      expect_vec("R1 owned", 2, 4'b0000);
      expect_vec("R1 pa", 3, 4'b0000, 2);
      compare_now();
      rst_n = 1'b1;

      // phase A: codes ch0=01 ch1=10 ch2=11 ch3=00
      ch_is_oc = 4'b1111;
      oc_mode  = 4'b0110;
      oc_level = 4'b0101;
      set_all_cmp(8'h10);
      count = 8'h0f; step();
      count = 8'h10; step();
      expect_vec("R2 flag set", 1, 4'b1111);
      expect_vec("R5 pin not yet", 0, 4'b0000);
      compare_now();
      count = 8'h11; step();
      expect_vec("R5 R6 R7 R4 pin action", 0, 4'b0101);
      expect_vec("R10 owned", 2, 4'b0111);
      expect_vec("R9 pa", 3, 4'b0010, 2);
      compare_now();

      // phase B: clear, then codes ch0=01 ch1=11 ch2=00 ch3=11
      flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      expect_vec("R3 flag clear", 1, 4'b0000);
      compare_now();
      oc_mode  = 4'b1010;
      oc_level = 4'b1011;
      count = 8'h10; step();
      expect_vec("R3 flag set again", 1, 4'b1111);
      expect_vec("R5 pin one clock late", 0, 4'b0101);
      compare_now();
      count = 8'h11; step();
      expect_vec("R4 R5 R7 pin", 0, 4'b1110);
      expect_vec("R10 owned", 2, 4'b1011);
      expect_vec("R9 pa none", 3, 4'b0000, 2);
      compare_now();

      // phase C: held count, single detection
      flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      count = 8'h10; step();
      expect_vec("R2 held flag", 1, 4'b1111);
      compare_now();
      flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      expect_vec("R3 clear in hold", 1, 4'b0000);
      expect_vec("R5 single toggle", 0, 4'b1111);
      compare_now();
      step();
      expect_vec("R2 no retrigger", 1, 4'b0000);
      expect_vec("R2 pin once", 0, 4'b1111);
      compare_now();

      // phase D: set wins over clear
      count = 8'h11; step();
      count = 8'h10; flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      expect_vec("R3 set beats clear", 1, 4'b1111);
      compare_now();
      count = 8'h11; step();
      expect_vec("R5 toggle back", 0, 4'b1110);
      compare_now();

      // phase E: ch0 not output compare
      flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      ch_is_oc = 4'b1110;
      count = 8'h10; step();
      expect_vec("R8 no flag", 1, 4'b1110);
      compare_now();
      count = 8'h11; step();
      expect_vec("R8 pin held", 0, 4'b1110);
      expect_vec("R10 owned dir", 2, 4'b1010);
      compare_now();

      // phase F: accumulator gating, codes ch1=11 others 00
      ch_is_oc = 4'b1111;
      oc_mode  = 4'b0010;
      oc_level = 4'b0010;
      pa_mask  = 4'b1000; step();
      expect_vec("R9 mask blocks hi", 3, 4'b0001, 2);
      compare_now();
      pa_mask = 4'b0000; step();
      expect_vec("R9 both free", 3, 4'b0011, 2);
      compare_now();
      ch_is_oc = 4'b0111; step();
      expect_vec("R9 dir blocks hi", 3, 4'b0001, 2);
      compare_now();

      // phase G: per-channel compare value
      ch_is_oc = 4'b1111;
      flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
      oc_mode  = 4'b0010;
      oc_level = 4'b0000;
      cmp_val[1*CW +: CW] = 8'h20;
      count = 8'h20; step();
      expect_vec("R11 own field flag", 1, 4'b0010);
      compare_now();
      count = 8'h21; step();
      expect_vec("R11 R6 own field pin", 0, 4'b1100);
      compare_now();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule